// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the control state machine of a single-wire bus transceiver. It tracks four operating modes (unpowered, pre-normal, normal and sleep) from a supply-good flag, an enable pin, the transmit pin level and a filtered wake-request pulse. From the mode it drives the switch for the external regulator inhibit, the bus termination switch and the transmit-path enable. It also drives the receive pin and the transmit-pin pull-down strength, which report a pending wake-up and where it came from.

The enable and transmit pins are asynchronous. Each passes through a register synchronizer, and enable edges are detected after it. A rising enable edge leads to normal mode after a programmable cycle delay. A falling enable edge leads to sleep after a second delay, but only when the synchronized transmit level is high at that edge. Only one delay counter is shared: a newly qualified edge restarts it towards a new target mode. Wake filtering and the dominant time-out guard are upstream of this block. The `wake_req_i` pulse is assumed to be already debounced. All control pins are plain levels, and the block has no streaming interface.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: When `supply_ok_i` is 1 in unpowered mode, the next clock edge enters pre-normal mode (`mode_o`=1). In pre-normal mode `inh_on_o`=1 and `term_on_o`=1, and with no wake pending `rxd_o`=1 and `txd_strong_pd_o`=0.
- R2: `supply_ok_i`=0 at a clock edge puts any mode into unpowered mode (`mode_o`=0) at that edge and drops any pending mode change. In unpowered mode `inh_on_o`, `term_on_o`, `tx_en_o` and `txd_strong_pd_o` are all 0 and `rxd_o`=1.
- R3: `en_i` and `txd_i` each pass through two register stages. The edge detector compares the second stage with its value one cycle earlier. A rising enable edge in pre-normal or sleep mode sets `mode_o`=2 (normal) at the (NORM_DLY+3)-th rising clock edge at which `en_i` is already high.
- R4: A falling enable edge in normal or pre-normal mode, with the synchronized transmit level high at the same edge, sets `mode_o`=3 (sleep) at the (SLEEP_DLY+3)-th rising clock edge at which `en_i` is already low.
- R5: A falling enable edge while the synchronized transmit level is low leaves the mode unchanged.
- R6: In sleep mode `inh_on_o`=0, `term_on_o`=0, `tx_en_o`=0, `rxd_o`=1 and `txd_strong_pd_o`=0.
- R7: A `wake_req_i` pulse in sleep mode enters pre-normal mode at the next edge. It turns inhibit and termination on, drives `rxd_o` to 0, and cancels any pending change to normal mode.
- R8: In pre-normal mode after a wake, `txd_strong_pd_o` equals the `wake_local_i` value captured with the wake pulse: 1 means strong pull-down for a local wake, 0 means weak pull-down for a remote wake.
- R9: The wake indication (`rxd_o` low) and the source indication clear at the edge after a rising enable edge is detected. This happens before the delayed switch to normal mode.
- R10: `tx_en_o`=1 only in normal mode. In normal mode `rxd_o` follows `bus_rx_i` with no register delay.
- R11: `wake_req_i` outside sleep mode has no effect on the mode or on the wake indications.
- R12: A qualified enable edge that arrives while a mode change is pending replaces the pending change and restarts the delay with the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply above operating threshold, synchronous |
| en_i | input | 1 | Enable pin, asynchronous |
| txd_i | input | 1 | Transmit pin level, asynchronous |
| wake_req_i | input | 1 | One-cycle filtered wake request |
| wake_local_i | input | 1 | Wake source tag: 1 local switch, 0 remote bus |
| bus_rx_i | input | 1 | Received bus level |
| mode_o | output | 2 | 0 unpowered, 1 pre-normal, 2 normal, 3 sleep |
| inh_on_o | output | 1 | Regulator inhibit switch on |
| term_on_o | output | 1 | Bus termination switch on |
| rxd_o | output | 1 | Receive pin level |
| txd_strong_pd_o | output | 1 | Transmit pin strong pull-down select |
| tx_en_o | output | 1 | Transmit path enable |

## Verification
The hardest case to reach is a second qualified enable edge that lands inside a running delay (R12). The bench holds enable high in pre-normal mode for only a few tens of cycles, well short of NORM_DLY, with transmit high. It then drops enable, so the sleep delay must replace the pending switch to normal. Clearing the wake flags one edge after a rising edge (R9) is sampled on both sides of that edge. The boundary cycles of both delays are sampled at the exact edge where the mode must change.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [1:0] {
    XM_OFF   = 2'd0,
    XM_PRE   = 2'd1,
    XM_RUN   = 2'd2,
    XM_SLEEP = 2'd3
  } xm_mode_e;
endpackage

// File: rtl/xm_sync.sv
module xm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xm_delay.sv
module xm_delay #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          cancel_i,
  input  logic [CW-1:0] val_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (cancel_i) begin
      busy_o <= 1'b0;
    end else if (load_i) begin
      cnt    <= val_i;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == CW'(1)) busy_o <= 1'b0;
      else               cnt    <= cnt - CW'(1);
    end
  end

  assign done_o = busy_o && (cnt == CW'(1));

  // R3: a running delay counts down by one per cycle
  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i && !cancel_i && cnt > CW'(1)) |=> (busy_o && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/xm_fsm.sv
module xm_fsm
  import xm_pkg::*;
#(
  parameter int CW        = 10,
  parameter int NORM_DLY  = 875,
  parameter int SLEEP_DLY = 750
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok_i,
  input  logic          en_rise_i,
  input  logic          en_fall_i,
  input  logic          txd_hi_i,
  input  logic          wake_req_i,
  input  logic          wake_local_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic          tmr_cancel_o,
  output logic [CW-1:0] tmr_val_o,
  output xm_mode_e      state_o,
  output logic          wake_flag_o,
  output logic          wake_loc_o
);
  xm_mode_e state_q, state_d, tgt_q, tgt_d;
  logic     flag_d, loc_d;

  always_comb begin
    state_d      = state_q;
    tgt_d        = tgt_q;
    flag_d       = wake_flag_o;
    loc_d        = wake_loc_o;
    tmr_load_o   = 1'b0;
    tmr_cancel_o = 1'b0;
    tmr_val_o    = CW'(NORM_DLY);
    if (!supply_ok_i) begin
      state_d      = XM_OFF;
      flag_d       = 1'b0;
      loc_d        = 1'b0;
      tmr_cancel_o = 1'b1;
    end else begin
      unique case (state_q)
        XM_OFF: begin
          state_d      = XM_PRE;
          flag_d       = 1'b0;
          loc_d        = 1'b0;
          tmr_cancel_o = 1'b1;
        end
        XM_PRE: begin
          if (en_rise_i) begin
            tmr_load_o = 1'b1;
            tgt_d      = XM_RUN;
            flag_d     = 1'b0;
            loc_d      = 1'b0;
          end else if (en_fall_i && txd_hi_i) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = CW'(SLEEP_DLY);
            tgt_d      = XM_SLEEP;
          end else if (tmr_done_i) begin
            state_d = tgt_q;
            if (tgt_q == XM_SLEEP) begin
              flag_d = 1'b0;
              loc_d  = 1'b0;
            end
          end
        end
        XM_RUN: begin
          if (en_fall_i && txd_hi_i) begin
            tmr_load_o = 1'b1;
            tmr_val_o  = CW'(SLEEP_DLY);
            tgt_d      = XM_SLEEP;
          end else if (tmr_done_i) begin
            state_d = tgt_q;
          end
        end
        XM_SLEEP: begin
          if (wake_req_i) begin
            state_d      = XM_PRE;
            flag_d       = 1'b1;
            loc_d        = wake_local_i;
            tmr_cancel_o = 1'b1;
          end else if (en_rise_i) begin
            tmr_load_o = 1'b1;
            tgt_d      = XM_RUN;
          end else if (tmr_done_i) begin
            state_d = tgt_q;
          end
        end
        default: state_d = XM_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= XM_OFF;
      tgt_q       <= XM_RUN;
      wake_flag_o <= 1'b0;
      wake_loc_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      tgt_q       <= tgt_d;
      wake_flag_o <= flag_d;
      wake_loc_o  <= loc_d;
    end
  end

  assign state_o = state_q;

  assert_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (state_q == XM_OFF && !wake_flag_o));
  assert_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XM_OFF && supply_ok_i) |=> (state_q == XM_PRE && !wake_flag_o));
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XM_SLEEP && supply_ok_i && wake_req_i) |=> (state_q == XM_PRE && wake_flag_o));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise_i && state_q == XM_PRE) |=> (!wake_flag_o && !wake_loc_o));
  assert_wake_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_i && supply_ok_i && state_q != XM_SLEEP && !wake_flag_o) |=> !wake_flag_o);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xm_pkg::*;
#(
  parameter int NORM_DLY    = 875,
  parameter int SLEEP_DLY   = 750,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_req_i,
  input  logic       wake_local_i,
  input  logic       bus_rx_i,
  output logic [1:0] mode_o,
  output logic       inh_on_o,
  output logic       term_on_o,
  output logic       rxd_o,
  output logic       txd_strong_pd_o,
  output logic       tx_en_o
);
  localparam int MAX_DLY = (NORM_DLY > SLEEP_DLY) ? NORM_DLY : SLEEP_DLY;
  localparam int CW      = $clog2(MAX_DLY + 1);

  logic [1:0]    pin_s;
  logic          en_s, txd_s, en_d, en_rise, en_fall;
  logic          tmr_load, tmr_cancel, tmr_busy, tmr_done;
  logic [CW-1:0] tmr_val;
  xm_mode_e      state;
  logic          wake_flag, wake_loc;

  xm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({txd_i, en_i}), .q_o(pin_s)
  );
  assign en_s  = pin_s[0];
  assign txd_s = pin_s[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en_s;

  assign en_rise = en_s & ~en_d;
  assign en_fall = ~en_s & en_d;

  xm_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .cancel_i(tmr_cancel),
    .val_i(tmr_val), .busy_o(tmr_busy), .done_o(tmr_done)
  );

  xm_fsm #(.CW(CW), .NORM_DLY(NORM_DLY), .SLEEP_DLY(SLEEP_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i),
    .en_rise_i(en_rise), .en_fall_i(en_fall), .txd_hi_i(txd_s),
    .wake_req_i(wake_req_i), .wake_local_i(wake_local_i),
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_cancel_o(tmr_cancel),
    .tmr_val_o(tmr_val), .state_o(state), .wake_flag_o(wake_flag),
    .wake_loc_o(wake_loc)
  );

  always_comb begin
    mode_o          = state;
    inh_on_o        = (state == XM_PRE) || (state == XM_RUN);
    term_on_o       = (state == XM_PRE) || (state == XM_RUN);
    tx_en_o         = (state == XM_RUN);
    txd_strong_pd_o = (state == XM_PRE) && wake_flag && wake_loc;
    unique case (state)
      XM_RUN:  rxd_o = bus_rx_i;
      XM_PRE:  rxd_o = ~wake_flag;
      default: rxd_o = 1'b1;
    endcase
  end

  // R5: an unqualified falling edge never starts a sleep entry from normal mode
  assert_sleep_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !txd_s && supply_ok_i && state == XM_RUN && !tmr_busy) |=> (mode_o == 2'd2));
endmodule

// File: tb/sim_xcvr_mode_ctrl.sv
module sim_xcvr_mode_ctrl;
  localparam int ND = 875;
  localparam int SD = 750;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok_i = 1'b0, en_i = 1'b0, txd_i = 1'b0;
  logic wake_req_i = 1'b0, wake_local_i = 1'b0, bus_rx_i = 1'b1;
  logic [1:0] mode_o;
  logic inh_on_o, term_on_o, rxd_o, txd_strong_pd_o, tx_en_o;

  always #4 clk = ~clk;

  xcvr_mode_ctrl #(.NORM_DLY(ND), .SLEEP_DLY(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .en_i(en_i),
    .txd_i(txd_i), .wake_req_i(wake_req_i), .wake_local_i(wake_local_i),
    .bus_rx_i(bus_rx_i), .mode_o(mode_o), .inh_on_o(inh_on_o),
    .term_on_o(term_on_o), .rxd_o(rxd_o), .txd_strong_pd_o(txd_strong_pd_o),
    .tx_en_o(tx_en_o)
  );

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  string cur = "R1";

  // behavioural reference model
  int m_mode, m_pend, m_cnt, m_wf, m_wl;
  bit e1, e2, e3, t1, t2;

  task automatic model_reset();
    m_mode = 0; m_pend = 0; m_cnt = 0; m_wf = 0; m_wl = 0;
    e1 = 0; e2 = 0; e3 = 0; t1 = 0; t2 = 0;
  endtask

  task automatic model_step();
    bit rise, fall;
    rise = e2 && !e3;
    fall = !e2 && e3;
    if (!supply_ok_i) begin
      m_mode = 0; m_pend = 0; m_wf = 0; m_wl = 0;
    end else begin
      case (m_mode)
        0: begin m_mode = 1; m_wf = 0; m_wl = 0; m_pend = 0; end
        1: if (rise) begin m_pend = 2; m_cnt = ND; m_wf = 0; m_wl = 0; end
           else if (fall && t2) begin m_pend = 3; m_cnt = SD; end
           else if (m_pend != 0) begin
             if (m_cnt == 1) begin
               m_mode = m_pend;
               if (m_pend == 3) begin m_wf = 0; m_wl = 0; end
               m_pend = 0;
             end else m_cnt--;
           end
        2: if (fall && t2) begin m_pend = 3; m_cnt = SD; end
           else if (m_pend != 0) begin
             if (m_cnt == 1) begin m_mode = m_pend; m_pend = 0; end
             else m_cnt--;
           end
        default: if (wake_req_i) begin
             m_mode = 1; m_wf = 1; m_wl = wake_local_i; m_pend = 0;
           end else if (rise) begin m_pend = 2; m_cnt = ND; end
           else if (m_pend != 0) begin
             if (m_cnt == 1) begin m_mode = m_pend; m_pend = 0; end
             else m_cnt--;
           end
      endcase
    end
    e3 = e2; e2 = e1; e1 = en_i;
    t2 = t1; t1 = txd_i;
  endtask

  task automatic cmp(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", cur, what, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) model_reset();
    else model_step();
    #2;
    if (rst_n && !finished) begin
      cmp("mode", mode_o, m_mode);
      cmp("inh", inh_on_o, (m_mode == 1 || m_mode == 2));
      cmp("term", term_on_o, (m_mode == 1 || m_mode == 2));
      cmp("txen", tx_en_o, (m_mode == 2));
      cmp("rxd", rxd_o, (m_mode == 2) ? int'(bus_rx_i) : (m_mode == 1) ? int'(!m_wf) : 1);
      cmp("strongpd", txd_strong_pd_o, (m_mode == 1 && m_wf == 1 && m_wl == 1));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic wake(bit loc);
    wake_local_i = loc; wake_req_i = 1'b1;
    cyc(1);
    wake_req_i = 1'b0;
  endtask

  initial begin
    model_reset();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    cur = "R2";
    chk("R2", "reset mode", mode_o, 0);
    chk("R2", "reset inh", inh_on_o, 0);

    cur = "R1";
    supply_ok_i = 1'b1;
    cyc(1);
    chk("R1", "powerup mode", mode_o, 1);
    chk("R1", "powerup inh", inh_on_o, 1);
    chk("R1", "powerup rxd", rxd_o, 1);

    cur = "R3";
    en_i = 1'b1;
    cyc(ND + 2);
    chk("R3", "before normal", mode_o, 1);
    cyc(1);
    chk("R3", "normal entry", mode_o, 2);
    chk("R10", "txen in normal", tx_en_o, 1);

    cur = "R10";
    for (int i = 0; i < 8; i++) begin
      bus_rx_i = i[0];
      #1;
      chk("R10", "rxd mirror", rxd_o, i[0]);
      cyc(1);
    end
    bus_rx_i = 1'b1;

    cur = "R11";
    wake(1'b1);
    cyc(2);
    chk("R11", "wake ignored in normal", mode_o, 2);

    cur = "R5";
    txd_i = 1'b0;
    en_i = 1'b0;
    cyc(SD + 50);
    chk("R5", "no sleep with txd low", mode_o, 2);
    en_i = 1'b1;
    cyc(10);

    cur = "R4";
    txd_i = 1'b1;
    cyc(3);
    en_i = 1'b0;
    cyc(SD + 2);
    chk("R4", "before sleep", mode_o, 2);
    cyc(1);
    chk("R4", "sleep entry", mode_o, 3);
    chk("R6", "sleep inh", inh_on_o, 0);
    chk("R6", "sleep term", term_on_o, 0);
    chk("R6", "sleep rxd", rxd_o, 1);

    cur = "R7";
    cyc(20);
    wake(1'b0);
    chk("R7", "wake to prenormal", mode_o, 1);
    chk("R7", "wake rxd low", rxd_o, 0);
    chk("R8", "remote weak pd", txd_strong_pd_o, 0);

    cur = "R9";
    en_i = 1'b1;
    cyc(2);
    chk("R9", "flag still set", rxd_o, 0);
    cyc(1);
    chk("R9", "flag cleared", rxd_o, 1);
    cyc(ND);
    chk("R3", "normal after wake", mode_o, 2);

    cur = "R8";
    cyc(5);
    en_i = 1'b0;
    cyc(SD + 10);
    chk("R4", "sleep again", mode_o, 3);
    wake(1'b1);
    chk("R8", "local strong pd", txd_strong_pd_o, 1);
    cur = "R11";
    wake(1'b0);
    cyc(2);
    chk("R11", "second wake ignored", txd_strong_pd_o, 1);

    cur = "R12";
    en_i = 1'b1;
    cyc(40);
    en_i = 1'b0;
    cyc(ND + 20);
    chk("R12", "sleep replaced normal", mode_o, 3);

    cur = "R3";
    en_i = 1'b1;
    cyc(ND + 2);
    chk("R3", "sleep before normal", mode_o, 3);
    cyc(1);
    chk("R3", "sleep to normal", mode_o, 2);

    cur = "R2";
    en_i = 1'b0;
    cyc(100);
    supply_ok_i = 1'b0;
    cyc(1);
    chk("R2", "supply loss mode", mode_o, 0);
    chk("R2", "supply loss txen", tx_en_o, 0);
    cyc(SD + 20);
    chk("R2", "pending dropped", mode_o, 0);
    supply_ok_i = 1'b1;
    cyc(1);
    chk("R1", "repowered", mode_o, 1);
    cyc(5);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog %s act=hung exp=done", cur);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule